// File: doc/BRIEF.md
# Neighbour Port Communication Module

This block connects a small 8-bit accumulator processor to four neighbour links: north, east, west and south. The processor writes registers through one write port: an output data byte, a configuration byte written with either a routing meaning or a command meaning, and three staging bytes A, B and C loaded from the accumulator. Each link has its own byte-wide input, byte-wide output and output enable. The enable stands in for a tri-state driver.

After a routing write, the upper nibble of the configuration register chooses which links broadcast the output data byte. The lower nibble picks one link whose byte is copied into the input register on every clock. After a command write, the same register starts one of two actions. A block transfer moves one to three staging bytes to a link, or from a link, at one byte per clock and then raises a done flag. A readback copies one staging byte to the accumulator.

The controller has three states. ST_IDLE accepts register writes. ST_MOVE carries a block transfer, one byte per cycle. ST_RDBK presents a readback byte for one cycle. The transitions are: ST_IDLE to ST_MOVE on a block command with a non-zero count; ST_IDLE to ST_RDBK on a valid readback command; ST_MOVE to ST_IDLE after the last byte; ST_RDBK to ST_IDLE after one cycle.

Top module: `nbr_port_top`

## Requirements
- R1: After reset the following are all zero: link_oe, link_out, in_data, cfg_data, acc_valid and busy.
- R2: The wr_sel codes are: 0 output data, 1 routing configuration, 2 command configuration, 3/4/5 staging A/B/C. After a routing write, cfg bits [7:4] (bit 4 N, 5 E, 6 W, 7 S) set link_oe. Any set of bits is allowed, so several links can broadcast together. Each enabled link carries the output data byte, and each disabled link outputs zero. Links are packed N, E, W, S from link bit 0 upward, one byte each.
- R3: In routing mode, when cfg bits [3:0] have exactly one bit set (bit 0 N, 1 E, 2 W, 3 S), in_data loads that link's input byte at every clock edge.
- R4: In routing mode, when cfg bits [3:0] have zero bits set or more than one bit set, in_data holds its value.
- R5: A command write with bits [7:6]=01 and bit 5=0 starts a block write. Bits [4:3] give the link (00 N, 01 E, 10 W, 11 S) and bits [2:1] give the count n. The transfer takes the n cycles after the write. In cycle k, only that link is enabled, and it carries staging byte k, in the order A, B, C.
- R6: A block command with bit 5=1 starts a block read. In each of the n cycles, staging byte k (order A, B, C) captures the selected link's input, and no link is enabled. Staging bytes at or beyond n keep their values.
- R7: A command write clears cfg bit 0 (done). When the last byte of a block transfer is moved, done becomes 1 and the other cfg bits keep the command. A block command with count 00 moves nothing and leaves done at 0.
- R8: busy is 1 while a block transfer or a readback is in progress. All register writes during that time are ignored, including a write that arrives in the final cycle.
- R9: A command with bits [7:6]=10 and bits [5:3] equal to 101, 110 or 111 sets acc_valid for exactly the one cycle after the write. acc_data then holds staging A, B or C respectively. Any other [5:3] value gives no pulse.
- R10: Staging bytes are loaded only by wr_sel 3 to 5 or by a block read. They are seen only through readback or through a block write.
- R11: While in command mode and no block write is in progress, all link enables are 0 and in_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 8 | Accumulator value being written |
| link_in | input | 32 | Input byte from each link, N in the low byte |
| link_out | output | 32 | Output byte to each link, zero when not enabled |
| link_oe | output | 4 | Output enable for each link |
| in_data | output | 8 | Input data register |
| cfg_data | output | 8 | Configuration register, including done in bit 0 |
| acc_data | output | 8 | Readback byte for the accumulator |
| acc_valid | output | 1 | Readback byte valid, one cycle |
| busy | output | 1 | Block transfer or readback in progress |

## Verification
The collision that matters is a processor write landing in the same cycle as a block transfer's final byte move. At that point the controller is finishing the transfer and setting done, so it could mistake the write for a new command. The bench starts a three-byte block write and then issues one write in each of the three move cycles. The last of these is a readback command timed to the final cycle. It then checks that the configuration register holds the block command with done set and that no readback pulse appears. It also checks that the output data byte and staging A still hold their earlier values when read back through the normal paths.

// File: rtl/nbr_port_pkg.sv
package nbr_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_RDBK = 2'd2
    } nbr_state_e;

    localparam logic [2:0] SEL_OUTD = 3'd0;
    localparam logic [2:0] SEL_PORT = 3'd1;
    localparam logic [2:0] SEL_CMD  = 3'd2;
    localparam logic [2:0] SEL_STGA = 3'd3;

    localparam logic [1:0] CMD_BLOCK = 2'b01;
    localparam logic [1:0] CMD_RDBK  = 2'b10;

    localparam int CFGW = 8;
    localparam int IDXW = 2;

endpackage

// File: rtl/nbr_port_fsm.sv
module nbr_port_fsm
    import nbr_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [2:0]      wr_sel,
    input  logic [CFGW-1:0] wr_cmd,
    input  logic [CFGW-1:0] cfg_q,
    output logic [IDXW-1:0] idx_q,
    output logic            done_set,
    output logic            mv_act,
    output logic            rb_act,
    output logic            busy
);

    nbr_state_e      state_q, state_d;
    logic [IDXW-1:0] idx_d;
    logic            cmd_go, blk_go, rb_go, last;

    assign cmd_go = accept && (wr_sel == SEL_CMD);
    assign blk_go = cmd_go && (wr_cmd[7:6] == CMD_BLOCK) && (wr_cmd[2:1] != 2'b00);
    assign rb_go  = cmd_go && (wr_cmd[7:6] == CMD_RDBK) && wr_cmd[5] && (wr_cmd[4:3] != 2'b00);
    assign last   = (idx_q == (cfg_q[2:1] - 2'd1));

    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        done_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (blk_go) begin
                    state_d = ST_MOVE;
                    idx_d   = '0;
                end else if (rb_go) begin
                    state_d = ST_RDBK;
                end
            end
            ST_MOVE: begin
                idx_d = idx_q + 2'd1;
                if (last) begin
                    state_d  = ST_IDLE;
                    done_set = 1'b1;
                end
            end
            ST_RDBK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        mv_act = (state_q == ST_MOVE);
        rb_act = (state_q == ST_RDBK);
        busy   = (state_q != ST_IDLE);
    end

    AST_MOVE_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_act && last) |=> cfg_q[0]); // R7
    AST_RDBK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rb_act |=> !rb_act); // R9
    AST_MOVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mv_act |-> (idx_q < cfg_q[2:1])); // R5

endmodule

// File: rtl/nbr_port_regs.sv
module nbr_port_regs
    import nbr_port_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NDIR = 4,
    parameter int NSTG = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic [2:0]               wr_sel,
    input  logic [DW-1:0]            wr_data,
    input  logic                     done_set,
    input  logic                     mv_act,
    input  logic [IDXW-1:0]          idx_q,
    input  logic [NDIR*DW-1:0]       link_in,
    output logic [DW-1:0]            out_q,
    output logic [DW-1:0]            in_q,
    output logic [CFGW-1:0]          cfg_q,
    output logic                     mode_cmd_q,
    output logic [NSTG-1:0][DW-1:0]  stg_q
);

    logic [NDIR-1:0] in_sel;
    logic [DW-1:0]   in_pick;
    logic            in_ok;
    logic [DW-1:0]   blk_pick;

    assign in_sel = cfg_q[NDIR-1:0];
    assign in_ok  = (in_sel != '0) && ((in_sel & (in_sel - 1'b1)) == '0);

    always_comb begin
        in_pick  = '0;
        blk_pick = '0;
        for (int d = 0; d < NDIR; d++) begin
            if (in_sel[d])
                in_pick = in_pick | link_in[d*DW +: DW];
            if (int'(cfg_q[4:3]) == d)
                blk_pick = link_in[d*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q      <= '0;
            in_q       <= '0;
            cfg_q      <= '0;
            mode_cmd_q <= 1'b0;
        end else begin
            if (accept && wr_sel == SEL_OUTD)
                out_q <= wr_data;
            if (accept && wr_sel == SEL_PORT) begin
                cfg_q      <= wr_data[CFGW-1:0];
                mode_cmd_q <= 1'b0;
            end else if (accept && wr_sel == SEL_CMD) begin
                cfg_q      <= {wr_data[CFGW-1:1], 1'b0};
                mode_cmd_q <= 1'b1;
            end else if (done_set) begin
                cfg_q[0] <= 1'b1;
            end
            if (!mode_cmd_q && in_ok)
                in_q <= in_pick;
        end
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_q[k] <= '0;
            end else if (accept && wr_sel == (SEL_STGA + 3'(k))) begin
                stg_q[k] <= wr_data;
            end else if (mv_act && cfg_q[5] && int'(idx_q) == k) begin
                stg_q[k] <= blk_pick;
            end
        end
    end

    AST_IN_HOLD_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cmd_q && $countones(cfg_q[NDIR-1:0]) != 1) |=> $stable(in_q)); // R4
    AST_IN_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cmd_q |=> $stable(in_q)); // R11

endmodule

// File: rtl/nbr_port_links.sv
module nbr_port_links
    import nbr_port_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NDIR = 4,
    parameter int NSTG = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_cmd_q,
    input  logic [CFGW-1:0]          cfg_q,
    input  logic [DW-1:0]            out_q,
    input  logic [NSTG-1:0][DW-1:0]  stg_q,
    input  logic [IDXW-1:0]          idx_q,
    input  logic                     mv_act,
    output logic [NDIR*DW-1:0]       link_out,
    output logic [NDIR-1:0]          link_oe
);

    logic [DW-1:0] blk_byte;

    always_comb begin
        blk_byte = '0;
        for (int k = 0; k < NSTG; k++)
            if (int'(idx_q) == k)
                blk_byte = stg_q[k];
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic blk_drive;
        assign blk_drive = mv_act && !cfg_q[5] && (int'(cfg_q[4:3]) == d);
        assign link_oe[d] = mode_cmd_q ? blk_drive : cfg_q[4+d];
        assign link_out[d*DW +: DW] = !link_oe[d] ? '0 :
                                      (mode_cmd_q ? blk_byte : out_q);
    end

    AST_CMD_ONE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cmd_q |-> $onehot0(link_oe)); // R5
    AST_CMD_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cmd_q && !mv_act) |-> (link_oe == '0)); // R11

endmodule

// File: rtl/nbr_port_top.sv
module nbr_port_top
    import nbr_port_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NDIR = 4,
    parameter int NSTG = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic [NDIR*DW-1:0] link_in,
    output logic [NDIR*DW-1:0] link_out,
    output logic [NDIR-1:0]    link_oe,
    output logic [DW-1:0]      in_data,
    output logic [CFGW-1:0]    cfg_data,
    output logic [DW-1:0]      acc_data,
    output logic               acc_valid,
    output logic               busy
);

    logic                    accept, done_set, mv_act, rb_act, mode_cmd_q;
    logic [IDXW-1:0]         idx_q;
    logic [DW-1:0]           out_q;
    logic [CFGW-1:0]         cfg_q;
    logic [NSTG-1:0][DW-1:0] stg_q;

    assign accept = wr_en && !busy;

    nbr_port_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .wr_sel   (wr_sel),
        .wr_cmd   (wr_data[CFGW-1:0]),
        .cfg_q    (cfg_q),
        .idx_q    (idx_q),
        .done_set (done_set),
        .mv_act   (mv_act),
        .rb_act   (rb_act),
        .busy     (busy)
    );

    nbr_port_regs #(.DW(DW), .NDIR(NDIR), .NSTG(NSTG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .done_set   (done_set),
        .mv_act     (mv_act),
        .idx_q      (idx_q),
        .link_in    (link_in),
        .out_q      (out_q),
        .in_q       (in_data),
        .cfg_q      (cfg_q),
        .mode_cmd_q (mode_cmd_q),
        .stg_q      (stg_q)
    );

    nbr_port_links #(.DW(DW), .NDIR(NDIR), .NSTG(NSTG)) u_links (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_cmd_q (mode_cmd_q),
        .cfg_q      (cfg_q),
        .out_q      (out_q),
        .stg_q      (stg_q),
        .idx_q      (idx_q),
        .mv_act     (mv_act),
        .link_out   (link_out),
        .link_oe    (link_oe)
    );

    assign cfg_data  = cfg_q;
    assign acc_valid = rb_act;

    always_comb begin
        acc_data = '0;
        for (int k = 0; k < NSTG; k++)
            if (rb_act && int'(cfg_q[4:3]) == k + 1)
                acc_data = stg_q[k];
    end

    AST_BUSY_IGNORES_OUTD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(out_q)); // R8
    AST_BUSY_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mv_act) |=> $stable(cfg_q)); // R8

endmodule

// File: tb/nbr_port_top_tb_top.sv
module nbr_port_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [7:0]  wr_data;
    logic [31:0] link_in;
    logic [31:0] link_out;
    logic [3:0]  link_oe;
    logic [7:0]  in_data;
    logic [7:0]  cfg_data;
    logic [7:0]  acc_data;
    logic        acc_valid;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nbr_port_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .link_in(link_in), .link_out(link_out),
        .link_oe(link_oe), .in_data(in_data), .cfg_data(cfg_data),
        .acc_data(acc_data), .acc_valid(acc_valid), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [7:0] lbyte(input logic [31:0] v, input int d);
        return v[d*8 +: 8];
    endfunction

    initial begin
        logic [7:0] exp_in;
        logic [3:0] prev_sel;
        logic [7:0] stage [3];
        logic [7:0] cmd;
        logic [7:0] held;

        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; link_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", 32'(link_oe), 0);
        check("R1 out", link_out, 0);
        check("R1 in", 32'(in_data), 0);
        check("R1 cfg", 32'(cfg_data), 0);
        check("R1 acc_valid", 32'(acc_valid), 0);
        check("R1 busy", 32'(busy), 0);

        // R2 broadcast sweep over every enable mask
        for (int m = 0; m < 16; m++) begin
            logic [7:0] od;
            od = 8'(8'h30 + m * 7);
            do_write(3'd0, od);
            do_write(3'd1, {4'(m), 4'b0000});
            check("R2 oe", 32'(link_oe), 32'(m));
            for (int d = 0; d < 4; d++)
                check("R2 link byte", 32'(lbyte(link_out, d)), m[d] ? 32'(od) : 0);
        end

        // R3 / R4 input select sweep
        exp_in   = 8'h00;
        prev_sel = 4'b0000;
        for (int s = 0; s < 16; s++) begin
            for (int d = 0; d < 4; d++)
                link_in[d*8 +: 8] = 8'(s * 16 + d + 1);
            do_write(3'd1, {4'b0000, 4'(s)});
            if ($countones(prev_sel) == 1)
                for (int d = 0; d < 4; d++)
                    if (prev_sel[d]) exp_in = 8'(s * 16 + d + 1);
            @(negedge clk);
            if ($countones(4'(s)) == 1)
                for (int d = 0; d < 4; d++)
                    if (s[d]) exp_in = 8'(s * 16 + d + 1);
            check(($countones(4'(s)) == 1) ? "R3 select" : "R4 hold", 32'(in_data), 32'(exp_in));
            prev_sel = 4'(s);
        end

        // R5 / R7 / R8 block writes
        for (int dir = 0; dir < 4; dir++) begin
            for (int n = 1; n < 4; n++) begin
                for (int k = 0; k < 3; k++) begin
                    stage[k] = 8'(dir * 64 + n * 16 + k + 1);
                    do_write(3'(3 + k), stage[k]);
                end
                cmd = {2'b01, 1'b0, 2'(dir), 2'(n), 1'b1};
                do_write(3'd2, cmd);
                check("R7 done cleared", 32'(cfg_data[0]), 0);
                for (int k = 0; k < n; k++) begin
                    check("R8 busy", 32'(busy), 1);
                    check("R5 oe", 32'(link_oe), 32'(1 << dir));
                    check("R5 byte", 32'(lbyte(link_out, dir)), 32'(stage[k]));
                    @(negedge clk);
                end
                check("R8 busy end", 32'(busy), 0);
                check("R7 done", 32'(cfg_data), 32'({cmd[7:1], 1'b1}));
                check("R11 quiet", 32'(link_oe), 0);
            end
        end

        // R6 / R9 / R10 / R11 block reads and readback
        held = in_data;
        for (int dir = 0; dir < 4; dir++) begin
            for (int n = 1; n < 4; n++) begin
                for (int k = 0; k < 3; k++) begin
                    stage[k] = 8'(8'hC0 + k);
                    do_write(3'(3 + k), stage[k]);
                end
                do_write(3'd2, {2'b01, 1'b1, 2'(dir), 2'(n), 1'b0});
                for (int k = 0; k < n; k++) begin
                    link_in = 32'hEEEE_EEEE;
                    link_in[dir*8 +: 8] = 8'(8'h50 + dir * 4 + k);
                    stage[k] = 8'(8'h50 + dir * 4 + k);
                    check("R6 no drive", 32'(link_oe), 0);
                    @(negedge clk);
                end
                check("R7 read done", 32'(cfg_data[0]), 1);
                for (int k = 0; k < 3; k++) begin
                    do_write(3'd2, {2'b10, 1'b1, 2'(k + 1), 3'b000});
                    check("R9 valid", 32'(acc_valid), 1);
                    check("R6 R10 readback", 32'(acc_data), 32'(stage[k]));
                    @(negedge clk);
                    check("R9 one cycle", 32'(acc_valid), 0);
                end
            end
        end
        check("R11 in held", 32'(in_data), 32'(held));

        // R7 count zero
        do_write(3'd2, 8'b01_0_01_00_1);
        check("R7 zero busy", 32'(busy), 0);
        check("R7 zero cfg", 32'(cfg_data), 32'(8'b01_0_01_00_0));
        check("R7 zero oe", 32'(link_oe), 0);

        // R9 invalid readback codes
        for (int c = 0; c < 5; c++) begin
            do_write(3'd2, {2'b10, 3'(c), 3'b000});
            check("R9 no pulse", 32'(acc_valid), 0);
        end

        // R8 writes during transfer, last one colliding with final byte
        do_write(3'd0, 8'h5A);
        do_write(3'd3, 8'h11);
        do_write(3'd2, 8'h46);
        do_write(3'd0, 8'hFF);
        do_write(3'd3, 8'hEE);
        do_write(3'd2, 8'hA8);
        check("R8 cfg kept", 32'(cfg_data), 32'h47);
        check("R8 no readback", 32'(acc_valid), 0);
        do_write(3'd2, 8'hA8);
        check("R8 stage kept", 32'(acc_data), 32'h11);
        @(negedge clk);
        do_write(3'd1, 8'h10);
        check("R8 outd kept", 32'(lbyte(link_out, 0)), 32'h5A);
        check("R2 single", 32'(link_oe), 32'h1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule